// File: doc/BRIEF.md
# Guarded Cache-Line Prefetch Issuer

This block takes prefetch hints from an instruction pipeline and decides whether each one becomes a line-fill request to memory. An operation brings a base operand, an index operand, a guard word and a flag saying whether a guard was supplied. The block scales the index by four, adds it to the base, and aligns the sum down to a 64-byte line. It presents that line address to a data-cache tag lookup port, and the port answers hit or miss in the same cycle.

A prefetch is only a hint. The block never stalls the pipeline for a prefetch it will not carry out. It drops the operation when the guard is false, when the line is already cached, or when two fills are already in flight. Surviving operations become a single request that is held until memory acknowledges it. A separate completion strobe retires in-flight fills. For every accepted operation, a debug code one cycle later reports what happened to it.

Top module: `prefetch_issuer`

## Requirements
- R1: The line address is (base + 4*index) modulo 2^32 with bits 5:0 cleared. It appears combinationally on `lookup_addr_o` and is carried to `fill_addr_o` when a request is issued.
- R2: With `guard_present_i` high, only bit 0 of `guard_i` matters. A 0 there drops the operation with outcome code 2'b01, whatever the other guard bits are.
- R3: With `guard_present_i` low, the operation proceeds as if the guard bit were 1, whatever `guard_i` holds.
- R4: If `lookup_hit_i` is high when an operation is accepted, no request is issued and the outcome code is 2'b10.
- R5: If the in-flight count before the accepting cycle is 2, the operation is dropped with outcome code 2'b11.
- R6: The in-flight count rises on `fill_req_o && fill_ack_i` and falls on `fill_done_i`. It stays unchanged when both happen in the same cycle, ignores a completion at zero, and never exceeds 2.
- R7: `fill_req_o` and `fill_addr_o` stay stable until `fill_ack_i`. `op_ready_o` is low while a request is pending, and an operation is accepted only when `op_valid_i` and `op_ready_o` are both high.
- R8: One cycle after each acceptance, `outcome_valid_o` is high for that one cycle with `outcome_o` set. Code 2'b00 (issued) comes with `fill_req_o` rising in that same cycle. The priority is guard-false over hit over miss-limit.
- R9: After reset, `op_ready_o` is high, `fill_req_o` and `outcome_valid_o` are low, and the in-flight count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Prefetch operation offered |
| op_ready_o | output | 1 | Block can accept an operation |
| base_i | input | 32 | Base operand |
| index_i | input | 32 | Index operand, scaled by 4 |
| guard_present_i | input | 1 | Operation carries a guard |
| guard_i | input | 32 | Guard word, only bit 0 used |
| lookup_addr_o | output | 32 | Line address to tag lookup |
| lookup_hit_i | input | 1 | Tag lookup reports line present |
| fill_req_o | output | 1 | Line-fill request pending |
| fill_addr_o | output | 32 | Line address of the pending fill |
| fill_ack_i | input | 1 | Memory accepts the pending fill |
| fill_done_i | input | 1 | One in-flight fill has completed |
| outcome_valid_o | output | 1 | Outcome code valid for the last accepted operation |
| outcome_o | output | 2 | 00 issued, 01 guard-false, 10 hit, 11 miss-limit |

## Verification
The line address is combinational, so it is due in the same cycle as the operands and is compared in the middle of each cycle against the operands present then. The request, the outcome code and the in-flight count each take one register stage. They are due on the clock edge after acceptance, or after the ack or completion strobe. The bench's reference model advances at each rising edge from the inputs driven on the previous falling edge. Its predictions are compared after the following falling edge, so every check samples a value one register stage after its cause and away from any active edge.

// File: rtl/prefetch_pkg.sv
package prefetch_pkg;
  typedef enum logic [1:0] {
    OUT_ISSUED   = 2'b00,
    OUT_GUARD    = 2'b01,
    OUT_HIT      = 2'b10,
    OUT_LIMIT    = 2'b11
  } outcome_e;
endpackage

// File: rtl/prefetch_addr_gen.sv
module prefetch_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SCALE_SH   = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  output logic [ADDR_W-1:0] line_o
);
  localparam logic [ADDR_W-1:0] LineMask = ~ADDR_W'(LINE_BYTES - 1);
  logic [ADDR_W-1:0] sum;
  // wraps modulo 2^ADDR_W
  assign sum    = base_i + (index_i << SCALE_SH);
  assign line_o = sum & LineMask;
endmodule

// File: rtl/prefetch_miss_ctr.sv
module prefetch_miss_ctr #(
  parameter int MAX_MISS = 2,
  parameter int CNT_W    = $clog2(MAX_MISS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q >= CNT_W'(MAX_MISS));
endmodule

// File: rtl/prefetch_req_reg.sv
module prefetch_req_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              req_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else if (issue_i) begin
      req_q  <= 1'b1;
      addr_q <= addr_i;
    end else if (req_q && ack_i) begin
      req_q  <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/prefetch_issuer.sv
module prefetch_issuer
  import prefetch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SCALE_SH   = 2,
  parameter int MAX_MISS   = 2,
  localparam int CNT_W     = $clog2(MAX_MISS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  output logic              op_ready_o,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic              guard_present_i,
  input  logic [ADDR_W-1:0] guard_i,
  output logic [ADDR_W-1:0] lookup_addr_o,
  input  logic              lookup_hit_i,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic              fill_ack_i,
  input  logic              fill_done_i,
  output logic              outcome_valid_o,
  output logic [1:0]        outcome_o
);
  logic [ADDR_W-1:0] line;
  logic [CNT_W-1:0]  miss_cnt;
  logic              at_limit;
  logic              accept, guard_ok, issue;
  outcome_e          outcome_d, outcome_q;
  logic              outcome_valid_q;

  prefetch_addr_gen #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SCALE_SH(SCALE_SH)
  ) u_addr (
    .base_i(base_i), .index_i(index_i), .line_o(line)
  );

  prefetch_miss_ctr #(.MAX_MISS(MAX_MISS), .CNT_W(CNT_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(fill_req_o && fill_ack_i), .dec_i(fill_done_i),
    .cnt_o(miss_cnt), .full_o(at_limit)
  );

  prefetch_req_reg #(.ADDR_W(ADDR_W)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .issue_i(issue), .addr_i(line), .ack_i(fill_ack_i),
    .req_o(fill_req_o), .addr_o(fill_addr_o)
  );

  assign op_ready_o    = !fill_req_o;
  assign accept        = op_valid_i && op_ready_o;
  assign guard_ok      = !guard_present_i || guard_i[0];
  assign lookup_addr_o = line;

  // priority: guard, then hit, then miss limit
  always_comb begin
    if (!guard_ok)         outcome_d = OUT_GUARD;
    else if (lookup_hit_i) outcome_d = OUT_HIT;
    else if (at_limit)     outcome_d = OUT_LIMIT;
    else                   outcome_d = OUT_ISSUED;
  end

  assign issue = accept && (outcome_d == OUT_ISSUED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outcome_valid_q <= 1'b0;
      outcome_q       <= OUT_ISSUED;
    end else begin
      outcome_valid_q <= accept;
      if (accept) outcome_q <= outcome_d;
    end
  end

  assign outcome_valid_o = outcome_valid_q;
  assign outcome_o       = outcome_q;
endmodule

// File: rtl/prefetch_issuer_chk.sv
module prefetch_issuer_chk #(
  parameter int ADDR_W   = 32,
  parameter int MAX_MISS = 2,
  parameter int CNT_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic              op_ready_o,
  input logic              fill_req_o,
  input logic              fill_ack_i,
  input logic              fill_done_i,
  input logic [ADDR_W-1:0] fill_addr_o,
  input logic              outcome_valid_o,
  input logic [1:0]        outcome_o,
  input logic [CNT_W-1:0]  miss_cnt
);
  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_ack_i) |=> (fill_req_o && $stable(fill_addr_o)));

  assert_line_align_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o |-> (fill_addr_o[5:0] == 6'd0));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_cnt <= CNT_W'(MAX_MISS));

  assert_cnt_inc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && fill_ack_i && !fill_done_i) |=> (miss_cnt == $past(miss_cnt) + CNT_W'(1)));

  assert_outcome_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outcome_valid_o |-> $past(op_valid_i && op_ready_o));

  assert_issue_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outcome_valid_o && outcome_o == 2'b00) |-> fill_req_o);

  assert_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outcome_valid_o && outcome_o == 2'b11) |-> ($past(miss_cnt) == CNT_W'(MAX_MISS)));
endmodule

bind prefetch_issuer prefetch_issuer_chk #(
  .ADDR_W(ADDR_W), .MAX_MISS(MAX_MISS), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_ready_o(op_ready_o),
  .fill_req_o(fill_req_o), .fill_ack_i(fill_ack_i), .fill_done_i(fill_done_i),
  .fill_addr_o(fill_addr_o), .outcome_valid_o(outcome_valid_o),
  .outcome_o(outcome_o), .miss_cnt(miss_cnt)
);

// File: tb/prefetch_issuer_bench.sv
`timescale 1ns/1ps
module prefetch_issuer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic        op_ready_o;
  logic [31:0] base_i = '0, index_i = '0, guard_i = '0;
  logic        guard_present_i = 1'b0;
  logic [31:0] lookup_addr_o;
  logic        lookup_hit_i;
  logic        fill_req_o;
  logic [31:0] fill_addr_o;
  logic        fill_ack_i = 1'b0, fill_done_i = 1'b0;
  logic        outcome_valid_o;
  logic [1:0]  outcome_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  prefetch_issuer u_prefetch_issuer (.*);

  function automatic bit cached(input logic [31:0] a);
    return (a == 32'h0000_1000) || (a == 32'h0000_2040) || (a == 32'h0000_3000);
  endfunction

  function automatic logic [31:0] line_of(input logic [31:0] b, input logic [31:0] i);
    longint s;
    s = longint'(b) + 4 * longint'(i);
    return 32'(s) & 32'hFFFF_FFC0;
  endfunction

  always_comb lookup_hit_i = cached(lookup_addr_o);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_cnt;
  bit          m_pend, m_ov;
  logic [31:0] m_addr;
  int          m_code;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_pend = 0; m_ov = 0; m_addr = '0; m_code = 0;
    end else begin
      bit acc, ack, g;
      logic [31:0] ln;
      int c_old;
      c_old = m_cnt;
      acc = op_valid_i && !m_pend;
      ack = m_pend && fill_ack_i;
      if (ack && !fill_done_i) m_cnt = m_cnt + 1;
      else if (!ack && fill_done_i && m_cnt > 0) m_cnt = m_cnt - 1;
      if (ack) m_pend = 0;
      m_ov = acc;
      if (acc) begin
        ln = line_of(base_i, index_i);
        g = guard_present_i ? guard_i[0] : 1'b1;
        if (!g) m_code = 1;
        else if (cached(ln)) m_code = 2;
        else if (c_old >= 2) m_code = 3;
        else begin
          m_code = 0; m_pend = 1; m_addr = ln;
        end
      end
    end
  end

  // per-cycle compare, mid-low phase
  always @(negedge clk_i) begin
    #2;
    if (rst_ni && !finished) begin
      chk(op_ready_o == !m_pend, "R7 ready", op_ready_o, !m_pend);
      chk(fill_req_o == m_pend, "R7 fill_req", fill_req_o, m_pend);
      if (m_pend) chk(fill_addr_o == m_addr, "R1 fill_addr", fill_addr_o, m_addr);
      chk(outcome_valid_o == m_ov, "R8 outcome_valid", outcome_valid_o, m_ov);
      if (m_ov) chk(outcome_o == 2'(m_code), "R8 outcome", outcome_o, m_code);
      chk(lookup_addr_o == line_of(base_i, index_i), "R1 lookup_addr",
          lookup_addr_o, line_of(base_i, index_i));
    end
  end

  task automatic do_op(input logic [31:0] b, input logic [31:0] i,
                       input bit gp, input logic [31:0] g);
    @(negedge clk_i);
    op_valid_i = 1; base_i = b; index_i = i; guard_present_i = gp; guard_i = g;
    while (!op_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    op_valid_i = 0;
  endtask

  task automatic expect_out(input logic [1:0] code, input string tag);
    #1;
    chk(outcome_valid_o === 1'b1, tag, outcome_valid_o, 1);
    chk(outcome_o === code, tag, outcome_o, code);
  endtask

  task automatic ack_once();
    @(negedge clk_i);
    while (!fill_req_o) @(negedge clk_i);
    fill_ack_i = 1;
    @(negedge clk_i);
    fill_ack_i = 0;
  endtask

  task automatic done_once();
    @(negedge clk_i);
    fill_done_i = 1;
    @(negedge clk_i);
    fill_done_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(op_ready_o === 1'b1, "R9 ready", op_ready_o, 1);
    chk(fill_req_o === 1'b0, "R9 fill_req", fill_req_o, 0);
    chk(outcome_valid_o === 1'b0, "R9 outcome_valid", outcome_valid_o, 0);
    rst_ni = 1;

    // R1 example: 0xabcd + 4*0xd -> line 0xac00
    do_op(32'hABCD, 32'hD, 1, 32'h1);
    expect_out(2'b00, "R1 issue");
    chk(fill_addr_o === 32'hAC00, "R1 addr", fill_addr_o, 32'hAC00);
    repeat (3) @(negedge clk_i);
    #1 chk(fill_req_o && fill_addr_o === 32'hAC00, "R7 hold", fill_addr_o, 32'hAC00);
    ack_once();

    // R2 guard LSB 0, upper bits set
    do_op(32'h5000, 32'h0, 1, 32'hFFFF_FFFE);
    expect_out(2'b01, "R2 guard false");
    #1 chk(fill_req_o === 1'b0, "R2 no req", fill_req_o, 0);

    // R3 no guard, guard word zero -> issue
    do_op(32'h6000, 32'h0, 0, 32'h0);
    expect_out(2'b00, "R3 guard absent");
    ack_once();

    // R5 two in flight -> limit
    do_op(32'h7000, 32'h1, 1, 32'h3);
    expect_out(2'b11, "R5 limit");

    // R4 hit takes priority over limit; R8 guard over hit
    do_op(32'h1000, 32'h0, 1, 32'h1);
    expect_out(2'b10, "R4 hit");
    do_op(32'h2000, 32'h10, 1, 32'h0);
    expect_out(2'b01, "R8 priority guard over hit");

    // R6 ack and done together: count stays 2-1=1 after done
    done_once();
    do_op(32'h8000, 32'h0, 0, 32'h0);
    expect_out(2'b00, "R6 after done");
    @(negedge clk_i);
    fill_ack_i = 1; fill_done_i = 1;
    @(negedge clk_i);
    fill_ack_i = 0; fill_done_i = 0;
    // count still 1 -> one more issue then limit
    do_op(32'h9000, 32'h0, 0, 32'h0);
    expect_out(2'b00, "R6 simultaneous");
    ack_once();
    do_op(32'hA000, 32'h0, 0, 32'h0);
    expect_out(2'b11, "R6 reached two");

    // R6 completions at zero are ignored
    repeat (4) done_once();
    do_op(32'hFFFF_FFF0, 32'h10, 1, 32'h1);
    expect_out(2'b00, "R6 done at zero");
    chk(fill_addr_o === 32'h0, "R1 wrap", fill_addr_o, 0);
    ack_once();
    do_op(32'hB000, 32'h0, 1, 32'h1);
    expect_out(2'b00, "R6 second");
    ack_once();
    do_op(32'hC000, 32'h0, 1, 32'h1);
    expect_out(2'b11, "R5 limit again");

    // random traffic
    for (int n = 0; n < 400; n++) begin
      @(negedge clk_i);
      fill_ack_i  = ($urandom_range(0, 2) == 0);
      fill_done_i = ($urandom_range(0, 3) == 0);
      op_valid_i  = ($urandom_range(0, 1) == 1);
      base_i      = {18'h0, 2'($urandom_range(0, 3)), 12'h000} + 32'($urandom_range(0, 80));
      index_i     = 32'($urandom_range(0, 20));
      guard_present_i = $urandom_range(0, 1) == 1;
      guard_i     = $urandom;
    end
    @(negedge clk_i);
    op_valid_i = 0; fill_ack_i = 0; fill_done_i = 0;
    repeat (4) @(negedge clk_i);
    #3;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule